// File: doc/BRIEF.md
# Indexed-Access Prioritized Interrupt Controller

This block collects up to 64 interrupt inputs and combines them into one host interrupt line. Each input has its own detection mode: rising edge, falling edge, active-high level or active-low level. Detected events are held in a per-input status bit. An input takes part in arbitration only while its enable bit is set. Each input is also given an 8-bit channel number, and a lower channel number means higher priority.

Software reaches the block through a 32-bit register port with a 13-bit byte address. Writes are registered and reads are combinational. A single status or enable bit is changed by writing an input's number to a dedicated index register. Several bits at once are changed through bank words with one bit per input. Software reads the winning input from a prioritized index register, and that register raises a flag in bit 31 when nothing is pending. The host line is gated by a global enable and by a host-output enable.

Top module: `pidx_intc`

## Requirements
- R1: After reset every register is 0, `host_irq` is low, and the prioritized index register (0x80) reads 0x8000_0000.
- R2: An input whose type bit is 1 is edge-detected: polarity bit 1 detects rising edges and 0 detects falling edges. The input passes through two synchronizing flops. The status bit becomes readable 3 clock edges after the input changes, and it stays set after the input returns. Status bank word n at 0x280+4n holds input 32n+b in bit b.
- R3: An input whose type bit is 0 is level-detected: polarity 1 means active high and 0 means active low. Its status bit stays set while the input is active, even across a status clear.
- R4: Writing a number to 0x24 clears only that input's status bit. Writing ones to status bank word 0x280+4n clears the matching status bits.
- R5: Writing a number to 0x28 sets that input's enable bit, and writing it to 0x2C clears it. A number of 64 or above changes nothing. Writing ones to 0x380+4n clears the matching enable bits, and reading 0x380+4n returns the enable bits.
- R6: Channel map word 0x400+4n holds the channel of input 4n+k in bits 8k+7:8k. The word reads back as written.
- R7: Register 0x80 reads the pending input (status and enable both set) that has the lowest channel number in bits 9:0, and ties go to the lower input number. When no input is pending it reads 0x8000_0000.
- R8: `host_irq` is high only when all of the following hold: global enable (0x10 bit 0) is 1, host enable is 1, and some input is pending. Writing 0 to 0x34 sets host enable and writing 0 to 0x38 clears it. Bit 0 of 0x1500 reads and writes host enable directly.
- R9: Polarity bank words at 0xD00+4n and type bank words at 0xD80+4n read back as written, with input 32n+b in bit b.
- R10: Index registers (0x24, 0x28, 0x2C, 0x34, 0x38) read 0. Writes to unmapped offsets change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | Interrupt inputs, asynchronous |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| host_irq | output | 1 | Host interrupt request |

## Verification
The assertions assume that the status-cause and level-hold relations are judged on the synchronized input, not on the raw pins. They also assume that a write strobe lasts one cycle and carries one address. The bench drives inputs and bus signals only on falling edges and pulses `bus_we` for a single cycle per access. Each input change is held for at least four cycles, so the synchronizer and edge detector always see a clean transition.

// File: rtl/pidx_intc.sv
module pidx_intc #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W  = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               host_irq
);
  localparam int A_GEN  = 'h10;
  localparam int A_SCLR = 'h24;
  localparam int A_ESET = 'h28;
  localparam int A_ECLR = 'h2C;
  localparam int A_HSET = 'h34;
  localparam int A_HCLR = 'h38;
  localparam int A_PRIO = 'h80;
  localparam int B_STAT = 'h280;
  localparam int B_ENCL = 'h380;
  localparam int B_CMAP = 'h400;
  localparam int B_POL  = 'hD00;
  localparam int B_TYP  = 'hD80;
  localparam int A_HEN  = 'h1500;

  logic [NUM_IRQ-1:0] s1, s2, s3, pol_q, typ_q, stat_q, en_q;
  logic [NUM_IRQ-1:0] lvl, edg, hit, pend, sclr_m, eset_m, eclr_m;
  logic [7:0]         chan_q [NUM_IRQ];
  logic               gen_q, hen_q, none;
  logic [9:0]         best, widx;
  logic [7:0]         bch;

  assign widx = bus_wdata[9:0];
  function automatic logic wr_at(input int off);
    return bus_we && (bus_addr == ADDR_W'(off));
  endfunction

  assign lvl  = ~(s2 ^ pol_q);
  assign edg  = (s2 ^ s3) & lvl;
  assign hit  = (typ_q & edg) | (~typ_q & lvl);
  assign pend = stat_q & en_q;
  assign host_irq = gen_q & hen_q & ~none;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      sclr_m[i] = (wr_at(A_SCLR) && widx == 10'(i)) ||
                  (wr_at(B_STAT + 4*(i/32)) && bus_wdata[i%32]);
      eset_m[i] = wr_at(A_ESET) && widx == 10'(i);
      eclr_m[i] = (wr_at(A_ECLR) && widx == 10'(i)) ||
                  (wr_at(B_ENCL + 4*(i/32)) && bus_wdata[i%32]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      stat_q <= '0; en_q <= '0; pol_q <= '0; typ_q <= '0;
      gen_q <= 1'b0; hen_q <= 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) chan_q[i] <= '0;
    end else begin
      s1 <= irq_in; s2 <= s1; s3 <= s2;
      stat_q <= hit | (stat_q & ~sclr_m);
      en_q   <= (en_q | eset_m) & ~eclr_m;
      if (wr_at(A_GEN)) gen_q <= bus_wdata[0];
      if (wr_at(A_HEN)) hen_q <= bus_wdata[0];
      else if (wr_at(A_HSET) && widx == 10'd0) hen_q <= 1'b1;
      else if (wr_at(A_HCLR) && widx == 10'd0) hen_q <= 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (wr_at(B_POL + 4*(i/32))) pol_q[i] <= bus_wdata[i%32];
        if (wr_at(B_TYP + 4*(i/32))) typ_q[i] <= bus_wdata[i%32];
        if (wr_at(B_CMAP + 4*(i/4))) chan_q[i] <= bus_wdata[8*(i%4) +: 8];
      end
    end
  end

  always_comb begin
    none = 1'b1;
    best = '0;
    bch  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && (none || chan_q[i] < bch)) begin
        none = 1'b0;
        best = 10'(i);
        bch  = chan_q[i];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_GEN))  bus_rdata[0] = gen_q;
    if (bus_addr == ADDR_W'(A_HEN))  bus_rdata[0] = hen_q;
    if (bus_addr == ADDR_W'(A_PRIO)) bus_rdata = {none, 21'd0, best};
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (bus_addr == ADDR_W'(B_STAT + 4*(i/32))) bus_rdata[i%32] = stat_q[i];
      if (bus_addr == ADDR_W'(B_ENCL + 4*(i/32))) bus_rdata[i%32] = en_q[i];
      if (bus_addr == ADDR_W'(B_POL + 4*(i/32)))  bus_rdata[i%32] = pol_q[i];
      if (bus_addr == ADDR_W'(B_TYP + 4*(i/32)))  bus_rdata[i%32] = typ_q[i];
      if (bus_addr == ADDR_W'(B_CMAP + 4*(i/4)))  bus_rdata[8*(i%4) +: 8] = chan_q[i];
    end
  end

  // R8
  host_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (gen_q && hen_q && (pend != '0)));
  // R7
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_PRIO) && bus_rdata[31]) |-> !host_irq);
  // R2
  stat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~$past(stat_q) & ~$past(hit)) == '0);
  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((stat_q & $past(hit)) == $past(hit)));
  // R5
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eclr_m != '0) |=> ((en_q & $past(eclr_m)) == '0));
endmodule

// File: tb/pidx_intc_test.sv
module pidx_intc_test;
  localparam int CLK_P = 10;
  localparam int N = 64;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, host_irq;
  logic [N-1:0] irq_in = '0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int n_chk = 0, n_err = 0;

  pidx_intc #(.NUM_IRQ(N), .ADDR_W(13)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .host_irq(host_irq));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic look(input logic [12:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [12:0] a, input logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk); look(a, d); chk(req, d, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 host_irq", {31'd0, host_irq}, 32'd0);
    rdchk("R1 prio", 13'h080, 32'h8000_0000);
    rdchk("R1 global", 13'h010, 32'd0);
    rdchk("R1 enable", 13'h380, 32'd0);
    rdchk("R1 polarity", 13'hD00, 32'd0);
  endtask

  task automatic t_setup;
    wr(13'hD80, '1); wr(13'hD84, '1);
    wr(13'hD00, '1); wr(13'hD04, '1);
    idle(4);
    wr(13'h280, '1); wr(13'h284, '1);
    rdchk("R4 bank clear w0", 13'h280, 32'd0);
    rdchk("R4 bank clear w1", 13'h284, 32'd0);
    wr(13'h010, 32'd1); wr(13'h034, 32'd0);
  endtask

  task automatic t_rise_edge;
    logic [31:0] d;
    wr(13'h028, 32'd5);
    @(negedge clk); irq_in[5] = 1'b1;
    idle(2); look(13'h080, d); chk("R2 not before third edge", d, 32'h8000_0000);
    idle(1); look(13'h080, d); chk("R2 latched at third edge", d, 32'd5);
    chk("R8 host on", {31'd0, host_irq}, 32'd1);
    wr(13'h024, 32'd5);
    rdchk("R4 index clear edge", 13'h080, 32'h8000_0000);
    @(negedge clk); irq_in[5] = 1'b0;
    idle(4);
    rdchk("R2 rising ignores fall", 13'h080, 32'h8000_0000);
  endtask

  task automatic t_fall_edge;
    wr(13'hD04, 32'hFFFF_FEFF);
    @(negedge clk); irq_in[40] = 1'b1; idle(4);
    rdchk("R2 falling ignores rise", 13'h284, 32'd0);
    @(negedge clk); irq_in[40] = 1'b0; idle(4);
    rdchk("R2 falling latched", 13'h284, 32'h100);
    rdchk("R7 disabled not pending", 13'h080, 32'h8000_0000);
    rdchk("R9 polarity readback", 13'hD04, 32'hFFFF_FEFF);
  endtask

  task automatic t_level;
    wr(13'hD80, 32'hFFFF_FF7F);
    rdchk("R9 type readback", 13'hD80, 32'hFFFF_FF7F);
    @(negedge clk); irq_in[7] = 1'b1; idle(4);
    rdchk("R3 high level set", 13'h280, 32'h80);
    wr(13'h024, 32'd7);
    rdchk("R3 hold across clear", 13'h280, 32'h80);
    @(negedge clk); irq_in[7] = 1'b0; idle(4);
    wr(13'h024, 32'd7);
    rdchk("R3 cleared when inactive", 13'h280, 32'd0);
    wr(13'hD00, 32'hFFFF_FF7F); idle(4);
    rdchk("R3 low level set", 13'h280, 32'h80);
    wr(13'hD00, '1); idle(4); wr(13'h024, 32'd7);
    rdchk("R3 low level cleared", 13'h280, 32'd0);
  endtask

  task automatic t_priority;
    wr(13'h404, 32'h0000_0300);
    wr(13'h408, 32'h0001_0000);
    wr(13'h428, 32'h0000_0001);
    rdchk("R6 map readback", 13'h404, 32'h0000_0300);
    rdchk("R6 map byte2", 13'h408, 32'h0001_0000);
    wr(13'h028, 32'd5); wr(13'h028, 32'd10); wr(13'h028, 32'd40);
    rdchk("R5 enable w0", 13'h380, 32'h420);
    rdchk("R5 enable w1", 13'h384, 32'h100);
    @(negedge clk); irq_in[5] = 1'b1; irq_in[10] = 1'b1; idle(4);
    @(negedge clk); irq_in[5] = 1'b0; irq_in[10] = 1'b0; idle(4);
    rdchk("R7 tie lower index", 13'h080, 32'd10);
    wr(13'h024, 32'd10);
    rdchk("R7 next lowest channel", 13'h080, 32'd40);
    wr(13'h024, 32'd40);
    rdchk("R7 last pending", 13'h080, 32'd5);
  endtask

  task automatic t_enable;
    wr(13'h02C, 32'd5);
    rdchk("R5 index clear", 13'h080, 32'h8000_0000);
    rdchk("R5 only one bit", 13'h380, 32'h400);
    wr(13'h380, 32'h400);
    rdchk("R5 bank clear", 13'h380, 32'd0);
    wr(13'h028, 32'd64);
    rdchk("R5 out of range w0", 13'h380, 32'd0);
    rdchk("R5 out of range w1", 13'h384, 32'h100);
  endtask

  task automatic t_gating;
    wr(13'h028, 32'd5);
    @(negedge clk); chk("R8 on", {31'd0, host_irq}, 32'd1);
    wr(13'h010, 32'd0);
    @(negedge clk); chk("R8 global off", {31'd0, host_irq}, 32'd0);
    rdchk("R7 index ungated", 13'h080, 32'd5);
    wr(13'h010, 32'd1); wr(13'h038, 32'd0);
    @(negedge clk); chk("R8 host clear", {31'd0, host_irq}, 32'd0);
    rdchk("R8 host enable reads 0", 13'h1500, 32'd0);
    wr(13'h1500, 32'd1);
    @(negedge clk); chk("R8 host bank set", {31'd0, host_irq}, 32'd1);
    rdchk("R8 host enable reads 1", 13'h1500, 32'd1);
  endtask

  task automatic t_unmapped;
    rdchk("R10 index reads 0 set", 13'h028, 32'd0);
    rdchk("R10 index reads 0 clr", 13'h024, 32'd0);
    rdchk("R10 host index reads 0", 13'h034, 32'd0);
    wr(13'h200, '1);
    rdchk("R10 unmapped read", 13'h200, 32'd0);
    rdchk("R10 write had no effect", 13'h080, 32'd5);
    @(negedge clk); chk("R10 host still on", {31'd0, host_irq}, 32'd1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_err);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_setup;
    t_rise_edge;
    t_fall_edge;
    t_level;
    t_priority;
    t_enable;
    t_gating;
    t_unmapped;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule